// File: doc/BRIEF.md
# Performance Counter Enable Control

This block keeps the run/stop state of a small performance monitor: three event counters and one cycle counter, all held inside the block. Software reaches the enable state through two views of one stored vector. Writing a 1 to the set view turns a counter on. Writing a 1 to the clear view turns it off. A 0 in either view leaves that bit as it is. Reading either view returns the same stored vector.

A separate control word holds a global run bit. When the global bit is 0, every counter stops, but the stored per-counter enables are kept and can still be changed. An event counter advances on a cycle where its event strobe is high, its own enable is set and the global bit is set. The cycle counter advances on every such cycle without needing a strobe. Counters wrap to zero and can be read at their own addresses.

There are three write strobes: set view, clear view and control word. They can fire in the same cycle. One read port returns a word selected by address, without a clock delay.

Top module: `perf_enable_ctl`

## Requirements
- R1: After reset every enable bit, the global run bit and all four counters read as zero.
- R2: A set-view write (read address 0) turns on each enable whose data bit is 1 and leaves bits written 0 unchanged. Bit 31 belongs to the cycle counter, and bits 2, 1 and 0 belong to event counters 2, 1 and 0.
- R3: A clear-view write (read address 1) turns off each enable whose data bit is 1 and leaves bits written 0 unchanged.
- R4: Writes to bits 30 down to 3 of either view have no effect, and those bits always read as zero.
- R5: Read addresses 0 and 1 both return the same stored enable vector.
- R6: When both views write a 1 to the same bit in one cycle, that bit ends up 0.
- R7: Bit 0 of the control word (read address 2, other bits read zero) is the global run bit. While it is 0, no counter changes.
- R8: While the global run bit is 0, the stored enables keep their values and can still be set and cleared.
- R9: Event counter i advances by one on each edge where its enable, the global bit and its strobe are all 1. The cycle counter advances on each edge where bit 31 and the global bit are both 1.
- R10: A write takes effect at the next clock edge. A counter update on that same edge uses the enable values from before the write.
- R11: Counters are CNT_W bits wide and wrap to zero. Event counters 0, 1 and 2 read at addresses 4, 5 and 6, the cycle counter reads at 7, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Set-view write strobe |
| set_data | input | 32 | Set-view write data |
| clr_we | input | 1 | Clear-view write strobe |
| clr_data | input | 32 | Clear-view write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_data | input | 32 | Control word write data; bit 0 is the global run bit |
| evt_strobe | input | NUM_EVT | One event pulse per event counter |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |

## Verification
Two things can land on the same clock edge: a write that changes an enable, and a count step that depends on that enable. The bench provokes this on purpose. It clears or sets an enable while that counter's strobe is high and the global bit is on. It also writes both views to one bit in the same cycle. Random traffic keeps creating such collisions. A bench model updates the counters from the enables held before the edge, and only then applies the clear-wins write rule. Each result is judged against that model on the cycle after the edge.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int DATA_W   = 32;
  localparam int CYC_BIT  = 31;
  localparam int ADDR_SET = 0;
  localparam int ADDR_CLR = 1;
  localparam int ADDR_CTL = 2;
  localparam int EVT_BASE = 4;
  localparam int ADDR_CYC = 7;

  // Writable enable positions: cycle bit plus the low event bits.
  function automatic logic [DATA_W-1:0] live_mask(input int num_evt);
    logic [DATA_W-1:0] m;
    m = '0;
    m[CYC_BIT] = 1'b1;
    for (int i = 0; i < num_evt; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Clear wins over set on a shared bit.
  function automatic logic [DATA_W-1:0] merge_enables(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] ons,
    input logic [DATA_W-1:0] offs
  );
    return (cur | ons) & ~offs;
  endfunction
endpackage

// File: rtl/perf_en_reg.sv
module perf_en_reg
  import perf_pkg::*;
#(
  parameter int NUM_EVT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [DATA_W-1:0] set_data,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              ctl_we,
  input  logic              ctl_bit,
  output logic [DATA_W-1:0] en_vec,
  output logic              glb_en,
  output logic [DATA_W-1:0] set_hits,
  output logic [DATA_W-1:0] clr_hits
);
  localparam logic [DATA_W-1:0] MASK = live_mask(NUM_EVT);

  assign set_hits = set_we ? (set_data & MASK) : '0;
  assign clr_hits = clr_we ? (clr_data & MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_vec <= '0;
      glb_en <= 1'b0;
    end else begin
      en_vec <= merge_enables(en_vec, set_hits, clr_hits);
      if (ctl_we) glb_en <= ctl_bit;
    end
  end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] step_wrap(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= step_wrap(count);
  end
endmodule

// File: rtl/perf_rd_mux.sv
module perf_rd_mux
  import perf_pkg::*;
#(
  parameter int NUM_EVT = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [DATA_W-1:0]        en_vec,
  input  logic                     glb_en,
  input  logic [NUM_EVT*CNT_W-1:0] evt_cnt,
  input  logic [CNT_W-1:0]         cyc_cnt,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int PAD_W = CNT_W + DATA_W;

  logic [DATA_W-1:0] evt_word [NUM_EVT];
  logic [PAD_W-1:0]  cyc_pad;
  logic [DATA_W-1:0] cyc_word;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_ext
    logic [PAD_W-1:0] pad;
    assign pad         = {{DATA_W{1'b0}}, evt_cnt[i*CNT_W +: CNT_W]};
    assign evt_word[i] = pad[DATA_W-1:0];
  end

  assign cyc_pad  = {{DATA_W{1'b0}}, cyc_cnt};
  assign cyc_word = cyc_pad[DATA_W-1:0];

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == ADDR_SET || int'(rd_addr) == ADDR_CLR) rd_data = en_vec;
    if (int'(rd_addr) == ADDR_CTL) rd_data = {{(DATA_W-1){1'b0}}, glb_en};
    if (int'(rd_addr) == ADDR_CYC) rd_data = cyc_word;
    for (int i = 0; i < NUM_EVT; i++)
      if (int'(rd_addr) == EVT_BASE + i) rd_data = evt_word[i];
  end
endmodule

// File: rtl/perf_enable_ctl.sv
module perf_enable_ctl
  import perf_pkg::*;
#(
  parameter int NUM_EVT = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic [31:0]        set_data,
  input  logic               clr_we,
  input  logic [31:0]        clr_data,
  input  logic               ctl_we,
  input  logic [31:0]        ctl_data,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data
);
  logic [DATA_W-1:0]        en_vec;
  logic                     glb_en;
  logic [DATA_W-1:0]        set_hits;
  logic [DATA_W-1:0]        clr_hits;
  logic [NUM_EVT:0]         inc_vec;
  logic [NUM_EVT*CNT_W-1:0] evt_cnt;
  logic [CNT_W-1:0]         cyc_cnt;
  logic                     unused_ctl;

  assign unused_ctl = ^ctl_data[31:1];

  perf_en_reg #(.NUM_EVT(NUM_EVT)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .ctl_we   (ctl_we),
    .ctl_bit  (ctl_data[0]),
    .en_vec   (en_vec),
    .glb_en   (glb_en),
    .set_hits (set_hits),
    .clr_hits (clr_hits)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign inc_vec[i] = en_vec[i] & glb_en & evt_strobe[i];
    perf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_vec[i]),
      .count (evt_cnt[i*CNT_W +: CNT_W])
    );
  end

  assign inc_vec[NUM_EVT] = en_vec[CYC_BIT] & glb_en;

  perf_counter #(.CNT_W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc_vec[NUM_EVT]),
    .count (cyc_cnt)
  );

  perf_rd_mux #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_mux (
    .rd_addr (rd_addr),
    .en_vec  (en_vec),
    .glb_en  (glb_en),
    .evt_cnt (evt_cnt),
    .cyc_cnt (cyc_cnt),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/perf_enable_ctl_chk.sv
module perf_enable_ctl_chk #(
  parameter int NUM_EVT = 3,
  parameter int CNT_W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             set_we,
  input logic [31:0]      set_data,
  input logic             clr_we,
  input logic [31:0]      clr_data,
  input logic [31:0]      en_vec,
  input logic             glb_en,
  input logic [NUM_EVT:0] inc_vec,
  input logic [CNT_W-1:0] cyc_cnt
);
  localparam logic [31:0] MASK = perf_pkg::live_mask(NUM_EVT);

  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec & ~MASK) == 32'd0);

  // R3 and R6: any bit cleared is 0 after the edge, whatever set did.
  a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_vec & $past(clr_data & MASK)) == 32'd0));

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> (($past(set_data & MASK) & ~en_vec) == 32'd0));

  a_r8_hold_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en_vec));

  a_r7_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (inc_vec == '0));

  a_r9_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && en_vec[31]) |=> (cyc_cnt == CNT_W'($past(cyc_cnt) + CNT_W'(1))));

  a_r7_cycle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> $stable(cyc_cnt));
endmodule

bind perf_enable_ctl perf_enable_ctl_chk #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .set_we   (set_we),
  .set_data (set_data),
  .clr_we   (clr_we),
  .clr_data (clr_data),
  .en_vec   (en_vec),
  .glb_en   (glb_en),
  .inc_vec  (inc_vec),
  .cyc_cnt  (cyc_cnt)
);

// File: tb/perf_enable_ctl_test.sv
`timescale 1ns/1ps
module perf_enable_ctl_test;
  localparam logic [31:0] MASK = 32'h8000_0007;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_we = 1'b0, clr_we = 1'b0, ctl_we = 1'b0;
  logic [31:0] set_data = '0, clr_data = '0, ctl_data = '0;
  logic [2:0]  evt_strobe = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data_s;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_en;
  logic        m_glb;
  logic [31:0] m_cnt [4];

  always #4 clk = ~clk;

  perf_enable_ctl uut (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .evt_strobe(evt_strobe), .rd_addr(rd_addr), .rd_data(rd_data));

  perf_enable_ctl #(.CNT_W(4)) uut_s (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .evt_strobe(evt_strobe), .rd_addr(rd_addr), .rd_data(rd_data_s));

  function automatic logic [31:0] expect_word(input int a);
    case (a)
      0, 1:    return m_en;
      2:       return {31'd0, m_glb};
      4, 5, 6: return m_cnt[a-4];
      7:       return m_cnt[3];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic s_we, input logic [31:0] s_d,
                      input logic c_we, input logic [31:0] c_d,
                      input logic k_we, input logic [31:0] k_d,
                      input logic [2:0] ev, input int a, input string tag);
    logic [31:0] exp, on_bits, off_bits;
    @(negedge clk);
    set_we = s_we; set_data = s_d; clr_we = c_we; clr_data = c_d;
    ctl_we = k_we; ctl_data = k_d; evt_strobe = ev;
    for (int i = 0; i < 3; i++)
      if (m_en[i] && m_glb && ev[i]) m_cnt[i] = m_cnt[i] + 1;
    if (m_en[31] && m_glb) m_cnt[3] = m_cnt[3] + 1;
    on_bits  = s_we ? (s_d & MASK) : 32'd0;
    off_bits = c_we ? (c_d & MASK) : 32'd0;
    m_en = (m_en | on_bits) & ~off_bits;
    if (k_we) m_glb = k_d[0];
    @(posedge clk);
    #1 rd_addr = a[2:0];
    #1;
    exp = expect_word(a);
    check(tag, rd_data, exp);
    check({tag, " narrow"}, rd_data_s, (a >= 4) ? (exp & 32'hF) : exp);
  endtask

  task automatic idle(input int a, input string tag, input logic [2:0] ev);
    step(1'b0, 32'd0, 1'b0, 32'd0, 1'b0, 32'd0, ev, a, tag);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1E));
    m_en = '0; m_glb = 1'b0;
    for (int i = 0; i < 4; i++) m_cnt[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state at every address
    for (int a = 0; a < 8; a++) idle(a, "R1", 3'b111);

    // R4: writing all ones sets only live bits; R5 both views agree
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 0, 3'b000, 0, "R4");
    idle(1, "R5", 3'b000);

    // global on, then R10: clear bit0 while its strobe is high
    step(1'b0, 0, 1'b0, 0, 1'b1, 32'h1, 3'b000, 2, "R7");
    step(1'b0, 0, 1'b1, 32'h1, 1'b0, 0, 3'b001, 4, "R10");
    idle(4, "R10", 3'b001);
    // R10: set bit0 with strobe high, old enable 0 means no count yet
    step(1'b1, 32'h1, 1'b0, 0, 1'b0, 0, 3'b001, 4, "R10");
    idle(4, "R10", 3'b001);

    // R3: clear one event bit
    step(1'b0, 0, 1'b1, 32'h2, 1'b0, 0, 3'b000, 1, "R3");
    // R6: set and clear collide on bit 0, bit 1 only set
    step(1'b1, 32'h3, 1'b1, 32'h1, 1'b0, 0, 3'b000, 0, "R6");

    // R7 and R8: global off, enables still editable, counters frozen
    step(1'b0, 0, 1'b0, 0, 1'b1, 32'h0, 3'b111, 2, "R7");
    step(1'b1, 32'h5, 1'b0, 0, 1'b0, 0, 3'b111, 0, "R8");
    step(1'b0, 0, 1'b1, 32'h8000_0000, 1'b0, 0, 3'b111, 1, "R8");
    for (int a = 4; a < 8; a++) idle(a, "R7", 3'b111);

    // R11: re-enable the cycle counter and let the narrow copy wrap
    step(1'b1, 32'h8000_0000, 1'b0, 0, 1'b1, 32'h1, 3'b000, 3, "R11");
    for (int k = 0; k < 20; k++) idle(7, "R11", 3'b000);

    // R9 plus every rule under random traffic
    for (int n = 0; n < 3000; n++) begin
      logic s_we_r, c_we_r, k_we_r;
      logic [31:0] s_r, c_r, k_r;
      int a;
      string tag;
      s_we_r = ($urandom % 4) == 0;
      c_we_r = ($urandom % 4) == 0;
      k_we_r = ($urandom % 16) == 0;
      s_r = $urandom;
      c_r = ($urandom % 2) ? s_r : $urandom;
      k_r = {$urandom, 1'b0} | {31'd0, ($urandom % 4) != 0};
      a = $urandom % 8;
      case (a)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R7";
        3: tag = "R11";
        default: tag = "R9";
      endcase
      step(s_we_r, s_r, c_we_r, c_r, k_we_r, k_r, 3'($urandom), a, tag);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule